// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in ordinary memory. The top ten address bits pick an entry in the outer table, the next ten bits pick an entry in the inner table named by that outer entry, and the low twelve bits pass through untouched as the offset into a 4 KiB frame. Each step is one word read over a simple valid/ready read port with a separate response strobe.

A request is taken only while the walker is idle. The table base and the table length are supplied as inputs along with the request and are captured when it is accepted. The walk ends in one of two ways. On success the walker gives the translated address and, in the same cycle, a fill record (virtual page number and frame number) for a translation buffer. Otherwise it gives a fault with a two-bit cause. Caching of results and writing status bits back to the tables are left to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: The outer entry is read at address pt_base + 4 * req_vaddr[31:22]. This is the first memory read of a walk.
- R2: The inner entry is read at address {outer entry[31:12], 12'h000} + 4 * req_vaddr[21:12]. This is the second memory read of a walk.
- R3: If req_vaddr[31:22] >= pt_len, the walk ends with rsp_fault=1 and rsp_cause=2'b01. No memory read is issued for it. An index of pt_len-1 passes this check.
- R4: An outer entry whose bit 0 (valid) is 0 ends the walk after exactly one read, with rsp_fault=1 and rsp_cause=2'b10.
- R5: An inner entry whose bit 0 is 0 ends the walk after exactly two reads, with rsp_fault=1 and rsp_cause=2'b11.
- R6: On success rsp_fault=0, rsp_cause=2'b00 and rsp_paddr={inner entry[31:12], req_vaddr[11:0]}. Entry bits 11:1 are reserved and have no effect.
- R7: A request is accepted only in a cycle where req_valid and req_ready are both 1. req_ready is 1 only while idle. req_valid, req_vaddr, pt_base and pt_len have no effect on a walk that is already in progress.
- R8: Each accepted request yields exactly one rsp_valid pulse, one cycle long. fill_valid is 1 in that same cycle only on success, with fill_vpn=req_vaddr[31:12] and fill_pfn=inner entry[31:12].
- R9: While mem_rd_valid is 1 and mem_rd_ready is 0, mem_rd_valid and mem_rd_addr hold their values.
- R10: After reset, req_ready=1 and rsp_valid, fill_valid and mem_rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| pt_base | input | 32 | Physical base address of the outer table |
| pt_len | input | 11 | Number of valid outer table entries |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_resp_valid | input | 1 | Read data is present |
| mem_resp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Walk result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | Fault cause: 01 length, 10 outer invalid, 11 inner invalid |
| rsp_paddr | output | 32 | Translated physical address |
| fill_valid | output | 1 | Fill record strobe for a translation buffer |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_pfn | output | 20 | Physical frame number of the fill |

## Verification
The walker is tried with full successful walks in which the offset is at both of its extremes. Two inner indices hang off a single outer entry, which shows that the inner index and the offset are separated correctly, and the reserved entry bits are set so that any leak would show. The length check is driven at index pt_len-1 and at index pt_len, with pt_len set to 0 and to 1024, which separates an off-by-one compare from a correct one. Invalid entries at each level tell the three fault causes apart by the number of reads they issue. Back-pressure with irregular latency, and junk requests held during a busy walk, show that an issued read stays stable and that a walk in progress cannot be disturbed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_OUTER,
    WS_WAIT_OUTER,
    WS_RD_INNER,
    WS_WAIT_INNER,
    WS_DONE,
    WS_FAULT
  } walk_state_t;

  typedef logic [1:0] fault_cause_t;

  localparam fault_cause_t CAUSE_NONE  = 2'b00;
  localparam fault_cause_t CAUSE_LEN   = 2'b01;
  localparam fault_cause_t CAUSE_OUTER = 2'b10;
  localparam fault_cause_t CAUSE_INNER = 2'b11;

endpackage

// File: rtl/ptw_va_split.sv
// Splits a virtual address into outer index, inner index and page offset.
module ptw_va_split #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]  va,
  output logic [IDX_W-1:0] hi_idx,
  output logic [IDX_W-1:0] lo_idx,
  output logic [OFF_W-1:0] offset
);
  localparam int LO_TOP = OFF_W + IDX_W - 1;

  assign hi_idx = va[VA_W-1 -: IDX_W];
  assign lo_idx = va[LO_TOP -: IDX_W];
  assign offset = va[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
// Byte address of a table entry: table base plus index scaled by entry size.
module ptw_entry_addr #(
  parameter int AW          = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam int SH = $clog2(ENTRY_BYTES);

  logic [AW-1:0] scaled;

  assign scaled = AW'(idx) << SH;
  assign addr   = base + scaled;
endmodule

// File: rtl/ptw_pte_decode.sv
// Field extraction for one table entry: frame number in the top bits, valid in bit 0.
module ptw_pte_decode #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       entry,
  output logic                   valid,
  output logic [PTE_W-OFF_W-1:0] frame
);
  localparam int FRAME_W = PTE_W - OFF_W;

  logic unused_rsvd;

  assign valid       = entry[0];
  assign frame       = entry[PTE_W-1 -: FRAME_W];
  assign unused_rsvd = ^entry[OFF_W-1:1];
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: owns the state register, the latched request and the read address.
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int AW      = 32,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [IDX_W-1:0]   req_hi_idx,
  input  logic [AW-1:0]      outer_addr,
  input  logic [AW-1:0]      inner_addr,
  input  logic [OFF_W-1:0]   cur_offset,
  input  logic               mem_rd_ready,
  input  logic               mem_resp_valid,
  input  logic               pte_valid,
  input  logic [FRAME_W-1:0] pte_frame,
  output logic [VA_W-1:0]    vaddr_q,
  output logic               req_ready,
  output logic               mem_rd_valid,
  output logic [AW-1:0]      mem_rd_addr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output fault_cause_t       rsp_cause,
  output logic [AW-1:0]      rsp_paddr,
  output logic               fill_valid,
  output logic [FRAME_W-1:0] fill_pfn
);
  walk_state_t        state_q;
  logic [AW-1:0]      rd_addr_q;
  fault_cause_t       cause_q;
  logic [FRAME_W-1:0] pfn_q;
  logic [OFF_W-1:0]   off_q;
  logic               len_bad;

  assign len_bad = {1'b0, req_hi_idx} >= {{(IDX_W+1-LEN_W){1'b0}}, req_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WS_IDLE;
      vaddr_q   <= '0;
      rd_addr_q <= '0;
      cause_q   <= CAUSE_NONE;
      pfn_q     <= '0;
      off_q     <= '0;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            if (len_bad) begin
              cause_q <= CAUSE_LEN;
              state_q <= WS_FAULT;
            end else begin
              rd_addr_q <= outer_addr;
              state_q   <= WS_RD_OUTER;
            end
          end
        end
        WS_RD_OUTER: begin
          if (mem_rd_ready) state_q <= WS_WAIT_OUTER;
        end
        WS_WAIT_OUTER: begin
          if (mem_resp_valid) begin
            if (!pte_valid) begin
              cause_q <= CAUSE_OUTER;
              state_q <= WS_FAULT;
            end else begin
              rd_addr_q <= inner_addr;
              state_q   <= WS_RD_INNER;
            end
          end
        end
        WS_RD_INNER: begin
          if (mem_rd_ready) state_q <= WS_WAIT_INNER;
        end
        WS_WAIT_INNER: begin
          if (mem_resp_valid) begin
            if (!pte_valid) begin
              cause_q <= CAUSE_INNER;
              state_q <= WS_FAULT;
            end else begin
              pfn_q   <= pte_frame;
              off_q   <= cur_offset;
              state_q <= WS_DONE;
            end
          end
        end
        WS_DONE:  state_q <= WS_IDLE;
        WS_FAULT: state_q <= WS_IDLE;
        default:  state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == WS_IDLE);
  assign mem_rd_valid = (state_q == WS_RD_OUTER) || (state_q == WS_RD_INNER);
  assign mem_rd_addr  = rd_addr_q;
  assign rsp_valid    = (state_q == WS_DONE) || (state_q == WS_FAULT);
  assign rsp_fault    = (state_q == WS_FAULT);
  assign rsp_cause    = (state_q == WS_FAULT) ? cause_q : CAUSE_NONE;
  assign rsp_paddr    = (state_q == WS_DONE) ? {pfn_q, off_q} : '0;
  assign fill_valid   = (state_q == WS_DONE);
  assign fill_pfn     = pfn_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W        = 32,
  parameter int IDX_W       = 10,
  parameter int OFF_W       = 12,
  parameter int PTE_W       = 32,
  parameter int ENTRY_BYTES = 4,
  localparam int FRAME_W    = PTE_W - OFF_W,
  localparam int AW         = FRAME_W + OFF_W,
  localparam int LEN_W      = IDX_W + 1,
  localparam int VPN_W      = VA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [AW-1:0]      pt_base,
  input  logic [LEN_W-1:0]   pt_len,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_resp_valid,
  input  logic [PTE_W-1:0]   mem_resp_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [AW-1:0]      rsp_paddr,
  output logic               fill_valid,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [FRAME_W-1:0] fill_pfn
);
  logic [IDX_W-1:0]   in_hi, unused_in_lo, unused_q_hi, q_lo;
  logic [OFF_W-1:0]   unused_in_off, q_off;
  logic [VA_W-1:0]    vaddr_q;
  logic               pte_valid;
  logic [FRAME_W-1:0] pte_frame;
  logic [AW-1:0]      outer_addr, inner_addr, inner_base;

  ptw_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_req (
    .va(req_vaddr), .hi_idx(in_hi), .lo_idx(unused_in_lo), .offset(unused_in_off)
  );

  ptw_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_hold (
    .va(vaddr_q), .hi_idx(unused_q_hi), .lo_idx(q_lo), .offset(q_off)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_pte (
    .entry(mem_resp_data), .valid(pte_valid), .frame(pte_frame)
  );

  assign inner_base = {pte_frame, {OFF_W{1'b0}}};

  ptw_entry_addr #(.AW(AW), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_ea_outer (
    .base(pt_base), .idx(in_hi), .addr(outer_addr)
  );

  ptw_entry_addr #(.AW(AW), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_ea_inner (
    .base(inner_base), .idx(q_lo), .addr(inner_addr)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .FRAME_W(FRAME_W), .AW(AW), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_len(pt_len),
    .req_hi_idx(in_hi), .outer_addr(outer_addr), .inner_addr(inner_addr),
    .cur_offset(q_off), .mem_rd_ready(mem_rd_ready),
    .mem_resp_valid(mem_resp_valid), .pte_valid(pte_valid), .pte_frame(pte_frame),
    .vaddr_q(vaddr_q), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_pfn(fill_pfn)
  );

  assign fill_vpn = vaddr_q[VA_W-1:OFF_W];
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [LEN_W-1:0] pt_len,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [1:0]       rsp_cause,
  input logic             fill_valid
);
  p_len_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: IDX_W]} >= pt_len))
    |=> (rsp_valid && rsp_fault && rsp_cause == 2'b01 && !mem_rd_valid));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_no_accept_while_reading_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_fill_only_success_r8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (rsp_valid && !rsp_fault));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W(VA_W), .IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .pt_len(pt_len), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .fill_valid(fill_valid)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] pt_base = '0;
  logic [10:0] pt_len = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [31:0] mem_rd_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic        rsp_valid, rsp_fault, fill_valid;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [19:0] fill_vpn, fill_pfn;

  ptw_walker dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic        fault;
    logic [1:0]  cause;
    logic [31:0] paddr;
    int          reads;
    logic [31:0] a1;
    logic [31:0] a2;
    logic [19:0] vpn;
    logic [19:0] pfn;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          rd_cnt = 0;
  bit          stall_mode = 0;
  bit          pend = 0;
  int          dly = 0;
  int          lat_ctr = 0;
  int          cyc = 0;
  logic [31:0] pend_addr;
  bit          prev_wait = 0;
  logic [31:0] prev_addr;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdmem(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(logic [31:0] va, logic [31:0] base, logic [10:0] len);
    exp_t e;
    logic [31:0] o, i;
    e.fault = 1'b1; e.paddr = '0; e.reads = 0; e.a1 = '0; e.a2 = '0;
    e.vpn = va[31:12]; e.pfn = '0; e.tag = "";
    if ({1'b0, va[31:22]} >= len) begin
      e.cause = 2'b01; e.tag = "R3"; return e;
    end
    e.a1 = base + 32'(va[31:22]) * 4;
    o = rdmem(e.a1);
    e.reads = 1;
    if (!o[0]) begin
      e.cause = 2'b10; e.tag = "R4"; return e;
    end
    e.a2 = {o[31:12], 12'h000} + 32'(va[21:12]) * 4;
    i = rdmem(e.a2);
    e.reads = 2;
    if (!i[0]) begin
      e.cause = 2'b11; e.tag = "R5"; return e;
    end
    e.fault = 1'b0; e.cause = 2'b00; e.tag = "R6";
    e.paddr = {i[31:12], va[11:0]};
    e.pfn = i[31:12];
    return e;
  endfunction

  // memory model and result monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_wait) begin
        chk("R9", "read held under stall", {31'h0, mem_rd_valid && (mem_rd_addr == prev_addr)}, 32'h1);
      end
      if (mem_resp_valid) mem_resp_valid = 1'b0;
      if (pend) begin
        if (dly <= 1) begin
          mem_resp_valid = 1'b1;
          mem_resp_data = rdmem(pend_addr);
          pend = 0;
        end else dly--;
      end
      mem_rd_ready = stall_mode ? ((cyc % 3) == 2) : 1'b1;
      cyc++;
      prev_wait = mem_rd_valid && !mem_rd_ready;
      prev_addr = mem_rd_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        if (exp_q.size() > 0) begin
          if (rd_cnt == 0) chk("R1", "outer entry address", mem_rd_addr, exp_q[0].a1);
          else chk("R2", "inner entry address", mem_rd_addr, exp_q[0].a2);
        end
        rd_cnt++;
        pend = 1;
        pend_addr = mem_rd_addr;
        dly = 1 + (lat_ctr % 3);
        lat_ctr++;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk("R8", "unexpected response", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.tag, "fault flag", {31'h0, rsp_fault}, {31'h0, e.fault});
          chk(e.tag, "fault cause", {30'h0, rsp_cause}, {30'h0, e.cause});
          chk(e.tag, "memory reads", 32'(rd_cnt), 32'(e.reads));
          if (!e.fault) begin
            chk(e.tag, "physical address", rsp_paddr, e.paddr);
            chk("R8", "fill vpn", {12'h0, fill_vpn}, {12'h0, e.vpn});
            chk("R8", "fill pfn", {12'h0, fill_pfn}, {12'h0, e.pfn});
          end
          chk("R8", "fill strobe", {31'h0, fill_valid}, {31'h0, !e.fault});
        end
        rd_cnt = 0;
      end
    end
  end

  task automatic walk(logic [31:0] va, logic [31:0] base, logic [10:0] len,
                      bit noise, string tag_override);
    exp_t e;
    e = model(va, base, len);
    if (tag_override != "") e.tag = tag_override;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    req_valid = 1'b1; req_vaddr = va; pt_base = base; pt_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    if (noise) begin
      req_vaddr = 32'hFFFF_F000; pt_base = 32'h0; pt_len = 11'd0;
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      req_valid = noise && !req_ready;
    end
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mkva(int hi, int lo, int off);
    return {10'(hi), 10'(lo), 12'(off)};
  endfunction

  localparam logic [31:0] B1 = 32'h0001_0000;
  localparam logic [31:0] B2 = 32'h0020_0000;

  initial begin
    mem[B1 + 32'd12]        = 32'h0004_0FFF;
    mem[32'h0004_0014]      = 32'hABCD_E7FF;
    mem[32'h0004_0018]      = 32'h1234_5001;
    mem[32'h0004_001C]      = 32'h5555_5FFE;
    mem[B1 + 32'd60]        = 32'hFFFF_FFFE;
    mem[B2 + 32'd4092]      = 32'h0008_0001;
    mem[32'h0008_0FFC]      = 32'h00AB_C001;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R10", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R10", "mem_rd_valid after reset", {31'h0, mem_rd_valid}, 32'h0);
    chk("R10", "fill_valid after reset", {31'h0, fill_valid}, 32'h0);

    walk(mkva(3, 5, 12'h123), B1, 11'd16, 0, "");   // R6 reserved bits set
    walk(mkva(3, 5, 12'hFFF), B1, 11'd16, 0, "");   // R6 offset top
    walk(mkva(3, 6, 12'h000), B1, 11'd16, 0, "");   // R6 offset zero, other inner
    walk(mkva(3, 7, 12'h0AA), B1, 11'd16, 0, "");   // R5
    walk(mkva(15, 0, 0), B1, 11'd16, 0, "");        // R4 at len-1
    walk(mkva(16, 0, 0), B1, 11'd16, 0, "");        // R3 at len
    walk(mkva(0, 0, 0), B1, 11'd0, 0, "");          // R3 zero length
    walk(mkva(3, 5, 12'h321), B1, 11'd4, 0, "");    // R3 boundary passes
    walk(mkva(1023, 1023, 12'h456), B2, 11'd1024, 0, ""); // R1 R2 top index
    walk(mkva(3, 6, 12'h777), B1, 11'd16, 1, "R7"); // junk held while busy
    walk(mkva(16, 0, 0), B1, 11'd16, 1, "R7");
    stall_mode = 1;
    walk(mkva(3, 6, 12'h010), B1, 11'd16, 0, "R9");
    walk(mkva(3, 7, 12'h020), B1, 11'd16, 0, "R9");
    walk(mkva(1023, 1023, 12'h001), B2, 11'd1024, 1, "R9");
    stall_mode = 0;
    repeat (4) @(negedge clk);
    chk("R8", "no stray response", {31'h0, rsp_valid}, 32'h0);
    chk("R7", "idle at end", {31'h0, req_ready}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule